// File: doc/BRIEF.md
# Programmable Synthesizer Divider Chain

This block produces the two comparison signals that a frequency-multiplying phase-locked loop compares. The feedback path takes a clock at the VCO rate, divides it by a fixed prescaler of eight, and then divides the result by a programmable modulus N. A 4-bit parallel code selects N, which is the code value plus 25, so N runs from 25 to 40. The feedback pulse therefore repeats every 8·N VCO cycles. The reference path divides a reference clock by its own fixed prescaler of eight.

Each comparison pulse also drives a toggle flop. The flop gives a half-rate square wave that can be watched on a test point. A single clear input restarts both chains. Each clock domain synchronizes the clear through its own two-flop stage before using it, and while the clear is seen high the counters, pulses and monitors of that domain stay at zero. A change of code never truncates the period in progress. The new modulus is captured only at the terminal count.

Top module: `syn_div_chain`

## Requirements
- R1: The feedback modulus is N = 25 + `mod_code`, with `mod_code[0]` the least and `mod_code[3]` the most significant bit. In steady state, rising `fb_pulse` events are 8·N `vco_clk` cycles apart.
- R2: `fb_pulse` is high for exactly one `vco_clk` cycle per period.
- R3: `ref_pulse` is high for exactly one `ref_clk` cycle and repeats every 8 `ref_clk` cycles.
- R4: If `mod_code` changes while a feedback period is running, that period still lasts 8·N(old). The period after it lasts 8·N(new).
- R5: While `clear` is high, once it has passed the synchronizer, `fb_pulse`, `ref_pulse`, `fb_mon` and `ref_mon` are all low.
- R6: After `clear` falls, count the first `vco_clk` rising edge that samples it low as edge 1. The first `fb_pulse` is then high right after edge 8·N+2. On the reference side, the first `ref_pulse` is high right after `ref_clk` edge 10.
- R7: `fb_mon` is cleared to 0 and toggles on the edge after each `fb_pulse`, and at no other time. It is therefore a half-rate copy of the feedback comparison signal.
- R8: `ref_mon` is cleared to 0 and toggles on the edge after each `ref_pulse`, and at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | VCO-rate clock of the feedback path |
| ref_clk | input | 1 | Reference clock of the reference path |
| clear | input | 1 | Asynchronous clear request, high = hold both chains at zero |
| mod_code | input | 4 | Modulus code, N = 25 + value |
| fb_pulse | output | 1 | One-cycle feedback comparison pulse (vco_clk domain) |
| ref_pulse | output | 1 | One-cycle reference comparison pulse (ref_clk domain) |
| fb_mon | output | 1 | Half-rate monitor of fb_pulse |
| ref_mon | output | 1 | Half-rate monitor of ref_pulse |

## Verification
Several properties are checked on every cycle in each clock domain:
- both pulses last a single cycle;
- a feedback pulse only follows a prescaler tick;
- the programmable count stays below the latched modulus;
- the latched modulus changes only at a terminal count or under clear;
- the monitors toggle exactly after a pulse;
- a synchronized clear silences the outputs.

The exact period for each of the 16 codes and the latency from clear release to the first pulse can only be shown by the bench's scenarios. So can the rule that a mid-period code change leaves the running period alone. The bench counts edges for these cases, using codes from directed sweeps and from seeded random choices.

// File: rtl/syn_div_pkg.sv
package syn_div_pkg;

  // Default sizing of the divider chain.
  localparam int DEF_CODE_W   = 4;
  localparam int DEF_MOD_BASE = 25;
  localparam int DEF_PRE_DIV  = 8;
  localparam int DEF_SYNC_LEN = 2;

  // Largest modulus reachable for a given code width and base.
  function automatic int mod_max(input int base, input int code_w);
    return base + (1 << code_w) - 1;
  endfunction

  // Width of a counter that must hold values up to and including hi.
  function automatic int width_for(input int hi);
    int w;
    w = 1;
    while ((1 << w) <= hi) w++;
    return w;
  endfunction

  // Modulus selected by a code: a plain offset from the base.
  function automatic int code_to_mod(input int base, input int code);
    return base + code;
  endfunction

endpackage

// File: rtl/sdc_clear_sync.sv
module sdc_clear_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_async,
  output logic clr_sync
);
  logic [STAGES-1:0] chain_q;

  // Stage 0 samples the raw request. Later stages shift it along.
  always_ff @(posedge clk) chain_q[0] <= clr_async;

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) chain_q[s] <= chain_q[s-1];
    end
  endgenerate

  assign clr_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sdc_prescaler.sv
module sdc_prescaler #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  generate
    if ((1 << CW) == DIV) begin : g_pow2
      // A power-of-two ratio wraps on its own.
      always_ff @(posedge clk) begin
        if (clr) cnt_q <= '0;
        else     cnt_q <= cnt_q + CW'(1);
      end
    end else begin : g_generic
      always_ff @(posedge clk) begin
        if (clr)          cnt_q <= '0;
        else if (at_last) cnt_q <= '0;
        else              cnt_q <= cnt_q + CW'(1);
      end
    end
  endgenerate

  assign tick = at_last && !clr;
endmodule

// File: rtl/sdc_mod_counter.sv
module sdc_mod_counter
  import syn_div_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int MOD_BASE = 25,
  parameter int CNT_W    = width_for(mod_max(MOD_BASE, CODE_W))
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              adv,
  input  logic [CODE_W-1:0] code,
  output logic              pulse,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  mod_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mod_q;
  logic [CNT_W-1:0] mod_next;
  logic             term;
  logic             pulse_q;

  // The code is only sampled here. The latched copy governs the period that is running.
  assign mod_next = CNT_W'(code_to_mod(MOD_BASE, int'(code)));
  assign term     = adv && (cnt_q == mod_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q   <= '0;
      mod_q   <= mod_next;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= term;
      if (term) begin
        cnt_q <= '0;
        mod_q <= mod_next;
      end else if (adv) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign pulse = pulse_q;
  assign cnt_o = cnt_q;
  assign mod_o = mod_q;
endmodule

// File: rtl/sdc_half_tap.sv
module sdc_half_tap (
  input  logic clk,
  input  logic clr,
  input  logic ev,
  output logic q
);
  logic q_r;

  always_ff @(posedge clk) begin
    if (clr)     q_r <= 1'b0;
    else if (ev) q_r <= ~q_r;
  end

  assign q = q_r;
endmodule

// File: rtl/syn_div_chain.sv
module syn_div_chain
  import syn_div_pkg::*;
#(
  parameter int CODE_W   = DEF_CODE_W,
  parameter int MOD_BASE = DEF_MOD_BASE,
  parameter int PRE_DIV  = DEF_PRE_DIV,
  parameter int SYNC_LEN = DEF_SYNC_LEN,
  localparam int CNT_W   = width_for(mod_max(MOD_BASE, CODE_W))
) (
  input  logic              vco_clk,
  input  logic              ref_clk,
  input  logic              clear,
  input  logic [CODE_W-1:0] mod_code,
  output logic              fb_pulse,
  output logic              ref_pulse,
  output logic              fb_mon,
  output logic              ref_mon
);
  // Named internal events, brought out for the checker.
  logic             fb_clr;
  logic             ref_clr;
  logic             fb_tick;
  logic             ref_tick;
  logic [CNT_W-1:0] fb_cnt;
  logic [CNT_W-1:0] fb_mod_q;
  logic             ref_pulse_q;

  // Feedback domain
  sdc_clear_sync #(.STAGES(SYNC_LEN)) u_fb_sync (
    .clk(vco_clk), .clr_async(clear), .clr_sync(fb_clr)
  );

  sdc_prescaler #(.DIV(PRE_DIV)) u_fb_pre (
    .clk(vco_clk), .clr(fb_clr), .tick(fb_tick)
  );

  sdc_mod_counter #(.CODE_W(CODE_W), .MOD_BASE(MOD_BASE), .CNT_W(CNT_W)) u_fb_mod (
    .clk(vco_clk), .clr(fb_clr), .adv(fb_tick), .code(mod_code),
    .pulse(fb_pulse), .cnt_o(fb_cnt), .mod_o(fb_mod_q)
  );

  sdc_half_tap u_fb_tap (
    .clk(vco_clk), .clr(fb_clr), .ev(fb_pulse), .q(fb_mon)
  );

  // Reference domain
  sdc_clear_sync #(.STAGES(SYNC_LEN)) u_ref_sync (
    .clk(ref_clk), .clr_async(clear), .clr_sync(ref_clr)
  );

  sdc_prescaler #(.DIV(PRE_DIV)) u_ref_pre (
    .clk(ref_clk), .clr(ref_clr), .tick(ref_tick)
  );

  // Register the tick so that both comparison pulses come from a flop.
  always_ff @(posedge ref_clk) begin
    if (ref_clr) ref_pulse_q <= 1'b0;
    else         ref_pulse_q <= ref_tick;
  end

  assign ref_pulse = ref_pulse_q;

  sdc_half_tap u_ref_tap (
    .clk(ref_clk), .clr(ref_clr), .ev(ref_pulse), .q(ref_mon)
  );
endmodule

// File: rtl/syn_div_chain_chk.sv
module syn_div_chain_chk #(
  parameter int CNT_W = 6
) (
  input logic             vco_clk,
  input logic             ref_clk,
  input logic             fb_clr,
  input logic             ref_clr,
  input logic             fb_tick,
  input logic [CNT_W-1:0] fb_cnt,
  input logic [CNT_W-1:0] fb_mod_q,
  input logic             fb_pulse,
  input logic             ref_pulse,
  input logic             fb_mon,
  input logic             ref_mon
);
  // Each domain is armed once its synchronized clear has been seen high.
  logic fb_armed  = 1'b0;
  logic ref_armed = 1'b0;

  always_ff @(posedge vco_clk) if (fb_clr)  fb_armed  <= 1'b1;
  always_ff @(posedge ref_clk) if (ref_clr) ref_armed <= 1'b1;

  p_fb_single_r2: assert property (@(posedge vco_clk) disable iff (!fb_armed || fb_clr)
    fb_pulse |=> !fb_pulse);

  p_fb_after_tick_r1: assert property (@(posedge vco_clk) disable iff (!fb_armed || fb_clr)
    $rose(fb_pulse) |-> $past(fb_tick));

  p_fb_cnt_bound_r1: assert property (@(posedge vco_clk) disable iff (!fb_armed || fb_clr)
    fb_cnt < fb_mod_q);

  p_mod_hold_r4: assert property (@(posedge vco_clk) disable iff (!fb_armed || fb_clr)
    !$stable(fb_mod_q) |-> (fb_pulse || $past(fb_clr)));

  p_fb_quiet_r5: assert property (@(posedge vco_clk) disable iff (!fb_armed)
    fb_clr |=> (!fb_pulse && !fb_mon));

  p_ref_quiet_r5: assert property (@(posedge ref_clk) disable iff (!ref_armed)
    ref_clr |=> (!ref_pulse && !ref_mon));

  p_ref_single_r3: assert property (@(posedge ref_clk) disable iff (!ref_armed || ref_clr)
    ref_pulse |=> !ref_pulse);

  p_fb_mon_flip_r7: assert property (@(posedge vco_clk) disable iff (!fb_armed || fb_clr)
    fb_pulse |=> (fb_mon != $past(fb_mon)));

  p_fb_mon_hold_r7: assert property (@(posedge vco_clk) disable iff (!fb_armed || fb_clr)
    !fb_pulse |=> $stable(fb_mon));

  p_ref_mon_flip_r8: assert property (@(posedge ref_clk) disable iff (!ref_armed || ref_clr)
    ref_pulse |=> (ref_mon != $past(ref_mon)));

  p_ref_mon_hold_r8: assert property (@(posedge ref_clk) disable iff (!ref_armed || ref_clr)
    !ref_pulse |=> $stable(ref_mon));
endmodule

bind syn_div_chain syn_div_chain_chk #(.CNT_W(CNT_W)) u_chk (
  .vco_clk(vco_clk), .ref_clk(ref_clk), .fb_clr(fb_clr), .ref_clr(ref_clr),
  .fb_tick(fb_tick), .fb_cnt(fb_cnt), .fb_mod_q(fb_mod_q),
  .fb_pulse(fb_pulse), .ref_pulse(ref_pulse), .fb_mon(fb_mon), .ref_mon(ref_mon)
);

// File: tb/syn_div_chain_test.sv
`timescale 1ns/1ps
module syn_div_chain_test;
  logic       vco_clk;
  logic       ref_clk;
  logic       clear;
  logic [3:0] mod_code;
  logic       fb_pulse, ref_pulse, fb_mon, ref_mon;

  int n_run  = 0;
  int n_fail = 0;

  syn_div_chain uut (
    .vco_clk(vco_clk), .ref_clk(ref_clk), .clear(clear), .mod_code(mod_code),
    .fb_pulse(fb_pulse), .ref_pulse(ref_pulse), .fb_mon(fb_mon), .ref_mon(ref_mon)
  );

  // 100 MHz VCO-side clock; slower reference clock with edges kept off the VCO grid.
  initial begin
    vco_clk = 1'b0;
    forever #5 vco_clk = ~vco_clk;
  end

  initial begin
    ref_clk = 1'b0;
    #2;
    forever #20 ref_clk = ~ref_clk;
  end

  // Expected modulus, written as a distance below the top of the range.
  function automatic int want_mod(input int code);
    return 40 - (15 - code);
  endfunction

  function automatic int want_first_fb(input int code);
    return 8 * want_mod(code) + 2;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic fb_wait(output int n);
    n = 0;
    do begin
      @(posedge vco_clk); #2;
      n++;
    end while (!fb_pulse && n < 1000);
  endtask

  task automatic ref_wait(output int n);
    n = 0;
    do begin
      @(posedge ref_clk); #4;
      n++;
    end while (!ref_pulse && n < 100);
  endtask

  // Hold clear, check that everything is quiet, release it, then time both chains.
  task automatic restart_and_check(input int code);
    int n;
    @(negedge vco_clk);
    clear    = 1'b1;
    mod_code = 4'(code);
    repeat (4) @(posedge ref_clk);
    repeat (3) @(posedge vco_clk);
    @(negedge vco_clk);
    chk("R5 quiet", int'({fb_pulse, ref_pulse, fb_mon, ref_mon}), 0);
    clear = 1'b0;
    fork
      begin
        fb_wait(n);
        chk($sformatf("R6 first fb code %0d", code), n, want_first_fb(code));
        @(posedge vco_clk); #2;
        chk("R2 fb width", int'(fb_pulse), 0);
        chk("R7 fb_mon rises", int'(fb_mon), 1);
        fb_wait(n);
        chk($sformatf("R1 period code %0d", code), n + 1, 8 * want_mod(code));
        chk("R7 fb_mon held", int'(fb_mon), 1);
        @(posedge vco_clk); #2;
        chk("R7 fb_mon falls", int'(fb_mon), 0);
      end
      begin
        ref_wait(n);
        chk("R6 first ref", n, 10);
        @(posedge ref_clk); #4;
        chk("R3 ref width", int'(ref_pulse), 0);
        chk("R8 ref_mon rises", int'(ref_mon), 1);
        ref_wait(n);
        chk("R3 ref period", n + 1, 8);
        @(posedge ref_clk); #4;
        chk("R8 ref_mon falls", int'(ref_mon), 0);
      end
    join
  endtask

  // Change the code partway through a period; sampling resumes one edge after a pulse.
  task automatic code_change(input int c_old, input int c_new);
    int n;
    restart_and_check(c_old);
    repeat (30) begin @(posedge vco_clk); #2; end
    mod_code = 4'(c_new);
    fb_wait(n);
    chk($sformatf("R4 running period %0d->%0d", c_old, c_new), n + 31, 8 * want_mod(c_old));
    fb_wait(n);
    chk($sformatf("R4 next period %0d->%0d", c_old, c_new), n, 8 * want_mod(c_new));
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    clear    = 1'b1;
    mod_code = 4'd0;
    seed     = $urandom(32'd20240);

    // Sweep every code: this covers both ends of the range and the bit order (R1).
    for (int c = 0; c < 16; c++) restart_and_check(c);

    // Seeded random codes
    for (int k = 0; k < 4; k++) restart_and_check(int'($urandom_range(15, 0)));

    // Directed code changes, including both extremes (R4)
    code_change(0, 15);
    code_change(15, 0);
    code_change(int'($urandom_range(15, 0)), int'($urandom_range(15, 0)));

    // A clear asserted mid-run restarts both chains from zero (R5, R6).
    restart_and_check(5);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule